// File: doc/BRIEF.md
# Three-Wire Serial Register Loader

This block takes a three-wire programming port (serial clock, serial data and a strobe) and turns it into two banks of parallel control fields. The host holds the strobe low, shifts one 21-bit word in most-significant bit first, and then raises the strobe. If the word carries this chip's address and exactly 21 bits arrived, its 16-bit payload is written into one of two working banks. A single bank-select bit in the word picks the bank.

The first bank holds the synthesizer settings: the main divider ratio, the reference divider select, the charge-pump current level and a mode select. The second bank holds a DC-offset trim code, two general-purpose logic outputs and six test bits. All three serial inputs are asynchronous to the system clock. Each passes through a two-flop synchroniser, and its edges are detected in the system clock domain. A synchronous reset loads every bank with its default value. The strobe is expected to be low while reset is applied.

Top module: `serial_cfg_loader`

## Requirements
- R1: While `rst` is high, and after it is released until a word is accepted, the outputs show the defaults: `div_ratio`=64, `ref_sel`=0, `cp_level`=0, `mode_sel`=0, `dc_trim`=128, `aux_out`=0, `test_bits`=0.
- R2: A word is 21 bits sent most-significant bit first. Bits 20..17 carry the chip address, bit 16 is the bank select, and bits 15..0 are the payload. Bank select 0 writes the synthesizer bank and bank select 1 writes the miscellaneous bank.
- R3: `ser_data` is shifted in on each rising edge of `ser_clk` that occurs while `ser_strobe` is low. Rising edges of `ser_clk` while `ser_strobe` is high are ignored and add nothing to the bit count.
- R4: The write happens only on a rising edge of `ser_strobe`. Outputs do not change while bits are being shifted. An accepted word appears at the outputs within 4 system clock cycles of the strobe rising.
- R5: A word whose address field differs from parameter `CHIP_ID` (default 4'b1010) leaves both banks unchanged.
- R6: A word with fewer or more than 21 clock edges between strobe rises leaves both banks unchanged. The bit count restarts at each strobe rise.
- R7: In the synthesizer bank, payload bits 8..0 drive `div_ratio`, bits 10..9 drive `ref_sel`, bits 13..11 drive `cp_level`, and bits 15..14 drive `mode_sel`.
- R8: In the miscellaneous bank, payload bits 7..0 drive `dc_trim`, bits 9..8 drive `aux_out`, and bits 15..10 drive `test_bits`.
- R9: A write to one bank leaves the other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data, asynchronous |
| ser_strobe | input | 1 | Serial strobe: low enables shifting, rising edge latches |
| div_ratio | output | 9 | Main divider ratio |
| ref_sel | output | 2 | Reference divider select |
| cp_level | output | 3 | Charge-pump current level |
| mode_sel | output | 2 | Mode select |
| dc_trim | output | 8 | DC-offset trim code |
| aux_out | output | 2 | General-purpose logic outputs |
| test_bits | output | 6 | Test control bits |

## Verification
Several properties are checked on every cycle:
- The banks never change except on the cycle after a detected strobe rise.
- A strobe rise with the wrong address or the wrong bit count leaves both banks alone.
- The shift register is frozen while the synchronised strobe is high.
- The bit counter never exceeds its saturation value.
- Reset loads the defaults.

Some behaviour only the bench's scenarios can show, because it depends on the field mapping and on the asynchronous serial timing:
- That each payload bit lands in the right output field.
- That the bank-select bit steers the write and the other bank is untouched.
- That clock pulses sent while the strobe is high spoil nothing.
- That a word appears within the stated latency.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int DIV_W    = 9;
  localparam int REFSEL_W = 2;
  localparam int CP_W     = 3;
  localparam int MODE_W   = 2;
  localparam int DC_W     = 8;
  localparam int AUX_W    = 2;
  localparam int TEST_W   = 6;

  // synthesizer bank layout (payload bit 15 at the top)
  typedef struct packed {
    logic [MODE_W-1:0]   mode;
    logic [CP_W-1:0]     cp;
    logic [REFSEL_W-1:0] refsel;
    logic [DIV_W-1:0]    div;
  } synth_t;

  // miscellaneous bank layout
  typedef struct packed {
    logic [TEST_W-1:0] test;
    logic [AUX_W-1:0]  aux;
    logic [DC_W-1:0]   dc;
  } misc_t;
endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q,
  output logic [W-1:0] rise
);
  logic [W-1:0] pipe [STAGES];
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) pipe[k] <= '0;
      prev <= '0;
    end else begin
      pipe[0] <= d_in;
      for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
      prev <= pipe[STAGES-1];
    end
  end

  assign q    = pipe[STAGES-1];
  assign rise = pipe[STAGES-1] & ~prev;
endmodule

// File: rtl/scl_shifter.sv
module scl_shifter #(
  parameter int WORD_W = 21,
  parameter int CNT_W  = $clog2(WORD_W + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  input  logic              clear,
  output logic [WORD_W-1:0] word_q,
  output logic [CNT_W-1:0]  cnt_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W + 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (shift_en) begin
        word_q <= {word_q[WORD_W-2:0], bit_in};
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
      if (clear) cnt_q <= '0;
    end
  end
endmodule

// File: rtl/scl_banks.sv
module scl_banks #(
  parameter int PAYLOAD_W = 16,
  parameter int NUM_BANKS = 2,
  parameter logic [NUM_BANKS*PAYLOAD_W-1:0] DEFAULTS = '0,
  localparam int SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [SEL_W-1:0]               wr_sel,
  input  logic [PAYLOAD_W-1:0]           wr_data,
  output logic [NUM_BANKS*PAYLOAD_W-1:0] bank_flat
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)
        bank_flat[b*PAYLOAD_W +: PAYLOAD_W] <= DEFAULTS[b*PAYLOAD_W +: PAYLOAD_W];
      else if (wr_en && wr_sel == SEL_W'(b))
        bank_flat[b*PAYLOAD_W +: PAYLOAD_W] <= wr_data;
    end
  end
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader #(
  parameter int ADDR_W      = 4,
  parameter logic [ADDR_W-1:0] CHIP_ID = 4'b1010,
  parameter int SYNC_STAGES = 2,
  parameter logic [15:0] SYNTH_DEFAULT = 16'h0040,
  parameter logic [15:0] MISC_DEFAULT  = 16'h0080
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ser_clk,
  input  logic                       ser_data,
  input  logic                       ser_strobe,
  output logic [scl_pkg::DIV_W-1:0]    div_ratio,
  output logic [scl_pkg::REFSEL_W-1:0] ref_sel,
  output logic [scl_pkg::CP_W-1:0]     cp_level,
  output logic [scl_pkg::MODE_W-1:0]   mode_sel,
  output logic [scl_pkg::DC_W-1:0]     dc_trim,
  output logic [scl_pkg::AUX_W-1:0]    aux_out,
  output logic [scl_pkg::TEST_W-1:0]   test_bits
);
  import scl_pkg::*;

  localparam int PAYLOAD_W = $bits(synth_t);
  localparam int WORD_W    = ADDR_W + 1 + PAYLOAD_W;
  localparam int CNT_W     = $clog2(WORD_W + 2);
  localparam logic [2*PAYLOAD_W-1:0] DEFAULTS = {MISC_DEFAULT, SYNTH_DEFAULT};

  logic [2:0] sync_q, sync_rise;
  logic strb_lvl, strb_rise, sclk_rise, sdata_lvl;

  scl_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .d_in({ser_strobe, ser_data, ser_clk}),
    .q(sync_q), .rise(sync_rise)
  );

  assign strb_lvl  = sync_q[2];
  assign strb_rise = sync_rise[2];
  assign sdata_lvl = sync_q[1];
  assign sclk_rise = sync_rise[0];

  logic [WORD_W-1:0] word_q;
  logic [CNT_W-1:0]  cnt_q;

  scl_shifter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst(rst),
    .shift_en(sclk_rise & ~strb_lvl),
    .bit_in(sdata_lvl),
    .clear(strb_rise),
    .word_q(word_q), .cnt_q(cnt_q)
  );

  logic [ADDR_W-1:0]    addr_field;
  logic                 sel_field;
  logic [PAYLOAD_W-1:0] payload;
  logic                 wr_en;

  assign addr_field = word_q[WORD_W-1 -: ADDR_W];
  assign sel_field  = word_q[PAYLOAD_W];
  assign payload    = word_q[PAYLOAD_W-1:0];
  assign wr_en      = strb_rise && (cnt_q == CNT_W'(WORD_W)) && (addr_field == CHIP_ID);

  logic [2*PAYLOAD_W-1:0] bank_flat;

  scl_banks #(.PAYLOAD_W(PAYLOAD_W), .NUM_BANKS(2), .DEFAULTS(DEFAULTS)) u_banks (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_sel(sel_field), .wr_data(payload),
    .bank_flat(bank_flat)
  );

  synth_t syn;
  misc_t  msc;
  assign syn = synth_t'(bank_flat[PAYLOAD_W-1:0]);
  assign msc = misc_t'(bank_flat[2*PAYLOAD_W-1:PAYLOAD_W]);

  assign div_ratio = syn.div;
  assign ref_sel   = syn.refsel;
  assign cp_level  = syn.cp;
  assign mode_sel  = syn.mode;
  assign dc_trim   = msc.dc;
  assign aux_out   = msc.aux;
  assign test_bits = msc.test;
endmodule

// File: rtl/serial_cfg_loader_chk.sv
module serial_cfg_loader_chk #(
  parameter int WORD_W = 21,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 5,
  parameter int BANK_W = 32,
  parameter logic [ADDR_W-1:0] CHIP_ID  = '0,
  parameter logic [BANK_W-1:0] DEFAULTS = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              strb_lvl,
  input logic              strb_rise,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [ADDR_W-1:0] addr_field,
  input logic [WORD_W-1:0] word_q,
  input logic [BANK_W-1:0] bank_flat
);
  p_defaults_r1: assert property (@(posedge clk) rst |=> (bank_flat == DEFAULTS));

  p_frozen_r3: assert property (@(posedge clk) disable iff (rst)
    strb_lvl |=> $stable(word_q));

  p_write_on_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    !strb_rise |=> $stable(bank_flat));

  p_addr_gate_r5: assert property (@(posedge clk) disable iff (rst)
    (strb_rise && addr_field != CHIP_ID) |=> $stable(bank_flat));

  p_len_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (strb_rise && cnt_q != CNT_W'(WORD_W)) |=> $stable(bank_flat));

  p_cnt_cap_r6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(WORD_W + 1));
endmodule

bind serial_cfg_loader serial_cfg_loader_chk #(
  .WORD_W(WORD_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BANK_W(2*PAYLOAD_W),
  .CHIP_ID(CHIP_ID), .DEFAULTS(DEFAULTS)
) u_chk (
  .clk(clk), .rst(rst), .strb_lvl(strb_lvl), .strb_rise(strb_rise),
  .cnt_q(cnt_q), .addr_field(addr_field), .word_q(word_q), .bank_flat(bank_flat)
);

// File: tb/tb_serial_cfg_loader.sv
module tb_serial_cfg_loader;
  localparam logic [3:0] ID = 4'b1010;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_strobe = 1'b0;
  logic [8:0] div_ratio;
  logic [1:0] ref_sel, mode_sel, aux_out;
  logic [2:0] cp_level;
  logic [7:0] dc_trim;
  logic [5:0] test_bits;

  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_syn = 16'h0040;
  logic [15:0] exp_msc = 16'h0080;

  always #5 clk = ~clk;

  serial_cfg_loader dut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data), .ser_strobe(ser_strobe),
    .div_ratio(div_ratio), .ref_sel(ref_sel), .cp_level(cp_level), .mode_sel(mode_sel),
    .dc_trim(dc_trim), .aux_out(aux_out), .test_bits(test_bits)
  );

  task automatic pause(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, "div_ratio", 16'(div_ratio), 16'(exp_syn[8:0]));
    chk(req, "ref_sel",   16'(ref_sel),   16'(exp_syn[10:9]));
    chk(req, "cp_level",  16'(cp_level),  16'(exp_syn[13:11]));
    chk(req, "mode_sel",  16'(mode_sel),  16'(exp_syn[15:14]));
    chk(req, "dc_trim",   16'(dc_trim),   16'(exp_msc[7:0]));
    chk(req, "aux_out",   16'(aux_out),   16'(exp_msc[9:8]));
    chk(req, "test_bits", 16'(test_bits), 16'(exp_msc[15:10]));
  endtask

  function automatic logic [31:0] mk(logic [3:0] a, logic s, logic [15:0] p);
    return {11'd0, a, s, p};
  endfunction

  // shift nbits of vec MSB first with the strobe low, strobe left low
  task automatic shift_bits(logic [31:0] vec, int nbits);
    ser_strobe = 1'b0;
    pause(3);
    for (int i = nbits - 1; i >= 0; i--) begin
      ser_data = vec[i];
      pause(3);
      ser_clk = 1'b1;
      pause(3);
      ser_clk = 1'b0;
    end
    pause(3);
  endtask

  task automatic model(logic [31:0] vec, int nbits);
    if (nbits == 21 && vec[20:17] == ID) begin
      if (vec[16]) exp_msc = vec[15:0];
      else         exp_syn = vec[15:0];
    end
  endtask

  task automatic send(logic [31:0] vec, int nbits, string req);
    shift_bits(vec, nbits);
    ser_strobe = 1'b1;
    pause(8);
    model(vec, nbits);
    check_all(req);
  endtask

  task automatic report;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    void'($urandom(32'd9107));
    pause(5);
    check_all("R1 during reset");
    rst = 1'b0;
    pause(4);
    check_all("R1");

    // R2 R7: synthesizer bank
    send(mk(ID, 1'b0, 16'hA5C3), 21, "R2 R7");
    // R8 R9: misc bank, synth bank kept
    send(mk(ID, 1'b1, 16'h3C96), 21, "R8 R9");
    send(mk(ID, 1'b0, 16'h5A3C), 21, "R9 synth rewrite");
    // R5: wrong address
    send(mk(ID ^ 4'b0001, 1'b0, 16'hFFFF), 21, "R5");
    send(mk(4'b0101, 1'b1, 16'h0000), 21, "R5");
    // R6: short and long words
    send(mk(ID, 1'b0, 16'h1234), 20, "R6 short");
    send({10'd0, 1'b0, ID, 1'b1, 16'hBEEF}, 22, "R6 long");

    // R4: nothing moves before strobe, update within 4 cycles after it
    shift_bits(mk(ID, 1'b1, 16'hC3A1), 21);
    check_all("R4 before strobe");
    ser_strobe = 1'b1;
    pause(4);
    model(mk(ID, 1'b1, 16'hC3A1), 21);
    check_all("R4 latency");

    // R3: clock pulses while strobe high must not count
    for (int i = 0; i < 5; i++) begin
      ser_data = 1'(i);
      pause(3); ser_clk = 1'b1; pause(3); ser_clk = 1'b0;
    end
    send(mk(ID, 1'b0, 16'h0F0F), 21, "R3");

    // random mix
    for (int n = 0; n < 60; n++) begin
      logic [3:0]  a;
      logic        s;
      logic [15:0] p;
      int          nb;
      a  = ($urandom_range(0, 9) < 7) ? ID : 4'($urandom_range(0, 15));
      s  = 1'($urandom_range(0, 1));
      p  = 16'($urandom);
      nb = ($urandom_range(0, 9) < 8) ? 21 : int'($urandom_range(18, 24));
      send(mk(a, s, p), nb, "R2 random");
    end

    report();
  end
endmodule